// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Multiplier

This block multiplies two binary floating-point numbers in the 32-bit single-precision layout: one sign bit, an 8-bit exponent with bias 127 and a 23-bit fraction. When a field describes a normal number, the block restores the hidden leading one. The work is split across two clocked stages. A new operand pair can be accepted on every cycle, and each result appears exactly two cycles after its operands.

The first stage classifies both operands and forms the result sign as the XOR of the input signs. In parallel, it adds the two biased exponents and multiplies the two 24-bit significands. The second stage removes the bias and normalises the significand product by at most one place. When the product is two or more, it shifts the significand one place right and raises the exponent by one. Rounding is always toward zero, which means the discarded low product bits are truncated.

The second stage also resolves the special operands: NaN, infinity and zero. It turns exponent overflow into infinity and exponent underflow into zero. Inputs whose exponent field is zero are flushed to zero, and no exception flags are produced.

Top module: `fpmul_pipe`

## Requirements
- R1: For every result that is not NaN, the sign bit (bit 31) equals the XOR of the sign bits of the two operands.
- R2: For two normal operands, when the significand product is below 2, the result exponent field is ea + eb − 127. The result fraction is bits 45..23 of the 48-bit product of the two 24-bit significands, with the lower bits discarded (round toward zero).
- R3: When the significand product is 2 or more (product bit 47 set), the fraction is product bits 46..24 and the exponent field is ea + eb − 126.
- R4: An operand whose exponent field is 0 is treated as zero whatever its fraction bits. A zero times a finite operand gives a zero with the R1 sign, encoded as exponent field 0 and fraction 0.
- R5: If either operand is a NaN (exponent field 255 with a nonzero fraction), the result is the quiet NaN 0x7FC00000.
- R6: Infinity (exponent field 255, fraction 0) times zero gives 0x7FC00000. Infinity times a normal number or an infinity gives infinity (exponent field 255, fraction 0) with the R1 sign.
- R7: For normal operands, a final exponent of 255 or more gives signed infinity, and a final exponent of 0 or less gives signed zero.
- R8: out_valid is high exactly two cycles after each cycle in which in_valid is high, and low otherwise. Operands offered on consecutive cycles each give a result, in order.
- R9: A synchronous active-high reset clears both pipeline valid bits, so out_valid is low during reset and for the two cycles after it unless new operands arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 32 | First operand, single-precision layout |
| in_b | input | 32 | Second operand, single-precision layout |
| out_valid | output | 1 | Product present this cycle |
| out_p | output | 32 | Product, single-precision layout |

## Verification
Two functions can meet in one cycle. A special-case decision can coincide with the exponent correction in stage 2: a product of 2 or more can carry a biased exponent that sat at 254 up to 255, so the carry and the overflow test act together. Near the bottom of the range, the carry can lift an underflowing exponent back into the normal range.

The sweep exercises these meetings by pairing every operand of a grid with every other. The grid crosses exponents near 1, 127 and 254 with fractions of 0, the least significant bit, one half and all ones. The operands go in back to back, with an occasional idle cycle. Each result is compared with a bench model that builds the expected word from field arithmetic. The model decides overflow only after it has applied the carry.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int WORD_W = 1 + EXP_W + MAN_W;
    localparam int SIG_W  = MAN_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int ESUM_W = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 1;

    typedef enum logic [1:0] {K_ZERO, K_NORM, K_INF, K_NAN} kind_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fp_t;

    typedef struct packed {
        logic              valid;
        kind_e             kind;
        logic              sign;
        logic [ESUM_W-1:0] esum;
        logic [PROD_W-1:0] prod;
    } s1_t;

    function automatic kind_e classify(input fp_t x);
        if (x.exp == '0)      return K_ZERO;
        else if (x.exp == '1) return (x.man != '0) ? K_NAN : K_INF;
        else                  return K_NORM;
    endfunction

    function automatic fp_t quiet_nan();
        fp_t r;
        r.sign = 1'b0;
        r.exp  = '1;
        r.man  = '0;
        r.man[MAN_W-1] = 1'b1;
        return r;
    endfunction

    function automatic fp_t make_inf(input logic s);
        fp_t r;
        r.sign = s;
        r.exp  = '1;
        r.man  = '0;
        return r;
    endfunction

    function automatic fp_t make_zero(input logic s);
        fp_t r;
        r.sign = s;
        r.exp  = '0;
        r.man  = '0;
        return r;
    endfunction
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
(
    input  fp_t              op,
    output kind_e            kind,
    output logic [SIG_W-1:0] sig
);
    always_comb begin
        kind = classify(op);
        sig  = {(kind == K_NORM), op.man};
    end
endmodule

// File: rtl/fpm_stage1.sv
module fpm_stage1
    import fpm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  fp_t  op_a,
    input  fp_t  op_b,
    output s1_t  s1_q
);
    kind_e            kind_a, kind_b;
    logic [SIG_W-1:0] sig_a, sig_b;
    s1_t              s1_d;

    fpm_unpack u_unpack_a (.op(op_a), .kind(kind_a), .sig(sig_a));
    fpm_unpack u_unpack_b (.op(op_b), .kind(kind_b), .sig(sig_b));

    always_comb begin
        s1_d.valid = in_valid;
        s1_d.sign  = op_a.sign ^ op_b.sign;
        s1_d.esum  = ESUM_W'(op_a.exp) + ESUM_W'(op_b.exp);
        s1_d.prod  = PROD_W'(sig_a) * PROD_W'(sig_b);
        if (kind_a == K_NAN || kind_b == K_NAN)
            s1_d.kind = K_NAN;
        else if ((kind_a == K_INF && kind_b == K_ZERO) || (kind_a == K_ZERO && kind_b == K_INF))
            s1_d.kind = K_NAN;
        else if (kind_a == K_INF || kind_b == K_INF)
            s1_d.kind = K_INF;
        else if (kind_a == K_ZERO || kind_b == K_ZERO)
            s1_d.kind = K_ZERO;
        else
            s1_d.kind = K_NORM;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q.valid <= 1'b0;
        end else begin
            s1_q.valid <= s1_d.valid;
        end
        s1_q.kind <= s1_d.kind;
        s1_q.sign <= s1_d.sign;
        s1_q.esum <= s1_d.esum;
        s1_q.prod <= s1_d.prod;
    end
endmodule

// File: rtl/fpm_stage2.sv
module fpm_stage2
    import fpm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  s1_t  s1_q,
    output logic out_valid,
    output fp_t  out_q
);
    localparam logic signed [ESUM_W:0] BIAS_S = (ESUM_W+1)'(BIAS);
    localparam logic signed [ESUM_W:0] TOP_S  = (ESUM_W+1)'(EXP_TOP);

    logic                    carry;
    logic signed [ESUM_W:0]  e_adj;
    logic [MAN_W-1:0]        man_n;
    fp_t                     res_d;
    logic                    unused_low;

    always_comb begin
        carry = s1_q.prod[PROD_W-1];
        e_adj = $signed({1'b0, s1_q.esum}) + $signed({{ESUM_W{1'b0}}, carry}) - BIAS_S;
        man_n = carry ? s1_q.prod[PROD_W-2 -: MAN_W] : s1_q.prod[PROD_W-3 -: MAN_W];
        unused_low = ^s1_q.prod[MAN_W-1:0];
        case (s1_q.kind)
            K_NAN:   res_d = quiet_nan();
            K_INF:   res_d = make_inf(s1_q.sign);
            K_ZERO:  res_d = make_zero(s1_q.sign);
            default: begin
                if (e_adj >= TOP_S)
                    res_d = make_inf(s1_q.sign);
                else if (e_adj <= 0)
                    res_d = make_zero(s1_q.sign);
                else begin
                    res_d.sign = s1_q.sign;
                    res_d.exp  = e_adj[EXP_W-1:0];
                    res_d.man  = man_n;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= s1_q.valid;
        out_q <= res_d;
    end

    // R7
    norm_range_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_q.valid && s1_q.kind == K_NORM) |=> (out_q.exp != '1 || out_q.man == '0));
endmodule

// File: rtl/fpmul_pipe.sv
module fpmul_pipe
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_p
);
    s1_t s1_q;
    fp_t out_q;

    fpm_stage1 u_stage1 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(fp_t'(in_a)), .op_b(fp_t'(in_b)), .s1_q(s1_q)
    );

    fpm_stage2 u_stage2 (
        .clk(clk), .rst(rst), .s1_q(s1_q),
        .out_valid(out_valid), .out_q(out_q)
    );

    assign out_p = out_q;

    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst)              warm <= 2'd0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    logic in_nan, in_num;
    always_comb begin
        in_nan = classify(fp_t'(in_a)) == K_NAN || classify(fp_t'(in_b)) == K_NAN ||
                 (classify(fp_t'(in_a)) == K_INF && classify(fp_t'(in_b)) == K_ZERO) ||
                 (classify(fp_t'(in_a)) == K_ZERO && classify(fp_t'(in_b)) == K_INF);
        in_num = !in_nan;
    end

    // R8
    valid_lag_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R5
    nan_out_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2 && $past(in_valid && in_nan, 2)) |-> (out_p == WORD_W'(quiet_nan())));

    // R1
    sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2 && $past(in_valid && in_num, 2)) |->
        (out_p[WORD_W-1] == $past(in_a[WORD_W-1] ^ in_b[WORD_W-1], 2)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !s1_q.valid));
endmodule

// File: tb/fpmul_pipe_tb_top.sv
module fpmul_pipe_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_p;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int wr = 0;
    int rd = 0;
    logic [31:0] exp_q [0:1299];
    string       tag_q [0:1299];
    int          iss_q [0:1299];
    bit          track = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fpmul_pipe dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_p(out_p)
    );

    function automatic logic [31:0] grid_op(input int i);
        int ex [0:8] = '{0, 1, 60, 64, 127, 128, 190, 254, 255};
        logic [22:0] mn [0:3] = '{23'h0, 23'h1, 23'h400000, 23'h7FFFFF};
        return {1'(i[0] ^ i[3]), 8'(ex[i / 4]), mn[i % 4]};
    endfunction

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b, output string tag);
        int ea = int'(a[30:23]);
        int eb = int'(b[30:23]);
        logic s = a[31] ^ b[31];
        bit na = (ea == 255) && (a[22:0] != 0);
        bit nb = (eb == 255) && (b[22:0] != 0);
        bit ia = (ea == 255) && (a[22:0] == 0);
        bit ib = (eb == 255) && (b[22:0] == 0);
        bit za = (ea == 0);
        bit zb = (eb == 0);
        longint p;
        int e;
        logic [22:0] m;
        if (na || nb) begin tag = "R5"; return 32'h7FC00000; end
        if ((ia && zb) || (za && ib)) begin tag = "R6"; return 32'h7FC00000; end
        if (ia || ib) begin tag = "R6"; return {s, 8'hFF, 23'h0}; end
        if (za || zb) begin tag = "R4"; return {s, 31'h0}; end
        p = longint'({1'b1, a[22:0]}) * longint'({1'b1, b[22:0]});
        e = ea + eb - 127;
        if (p >= (64'sd1 <<< 47)) begin
            e = e + 1;
            m = 23'(p >>> 24);
            tag = "R3";
        end else begin
            m = 23'(p >>> 23);
            tag = "R2";
        end
        if (e >= 255) begin tag = "R7"; return {s, 8'hFF, 23'h0}; end
        if (e <= 0)   begin tag = "R7"; return {s, 31'h0}; end
        return {s, 8'(e), m};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (track && out_valid) begin
            if (rd >= wr) begin
                check(1'b0, "R8", 32'(rd), 32'(wr));
            end else begin
                check(out_p == exp_q[rd], tag_q[rd], out_p, exp_q[rd]);
                if (exp_q[rd] != 32'h7FC00000)
                    check(out_p[31] == exp_q[rd][31], "R1", 32'(out_p[31]), 32'(exp_q[rd][31]));
                check(cyc - iss_q[rd] == 2, "R8", 32'(cyc - iss_q[rd]), 32'd2);
                rd++;
            end
        end
    end

    initial begin
        string t;
        int cnt = 0;
        rst = 1'b1;
        in_valid = 1'b1;
        in_a = 32'h3F800000;
        in_b = 32'h40000000;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R9", 32'(out_valid), 32'd0);
        end
        in_valid = 1'b0;
        rst = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R9", 32'(out_valid), 32'd0);
        end
        track = 1'b1;
        for (int i = 0; i < 36; i++) begin
            for (int j = 0; j < 36; j++) begin
                if (cnt % 7 == 6) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                cnt++;
                in_a = grid_op(i);
                in_b = grid_op(j);
                in_valid = 1'b1;
                exp_q[wr] = model(in_a, in_b, t);
                tag_q[wr] = t;
                iss_q[wr] = cyc;
                wr++;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(rd == wr, "R8", 32'(rd), 32'(wr));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule